// File: doc/BRIEF.md
# Embedded Core Timer Unit with Two-Stage Watchdog

This block holds the three timers that sit next to an embedded processor core. A programmable interval timer counts down on a tick enable and can reload itself. A fixed-interval timer raises an event each time a chosen bit of an external 64-bit time base changes. A watchdog advances through two warning stages on the transitions of another chosen time-base bit, and then issues a reset request.

Software sets the unit up through a 32-bit control register. It observes the unit through a 32-bit status register in which bits are cleared by writing ones. The watchdog keeps its stage in two status bits, so software services it by clearing those bits. When the final stage is reached, a two-bit reset kind taken from the control register is copied into the status register. A one-cycle reset request then goes out carrying that kind: 1 for core, 2 for chip, 3 for system. The reset logic that acts on the request is outside this block.

Top module: `core_timer_unit`

## Requirements
- R1: After a synchronous reset the control, status and interval-count values are zero, and every interrupt and the reset request are low.
- R2: A control write stores bits 31:22 and reads bits 21:0 as zero. Bits 31:30 select the watchdog tap, 29:28 give the reset kind, 27 enables the watchdog interrupt, 26 enables the interval timer and its interrupt, 25:24 select the fixed-interval tap, 23 enables the fixed-interval interrupt and 22 enables auto-reload. Once bits 29:28 hold a non-zero value, later writes leave them unchanged until reset.
- R3: Status bits are cleared by writing ones to them. A bit that a timer event sets in the same cycle as a clear ends up set.
- R4: The fixed-interval tap is time-base bit 9, 13, 17 or 21 for select 0 to 3. Every transition of the selected bit, rising or falling, sets status bit 26 at the next clock edge. Transitions of the other candidate bits do nothing. The first cycle after reset only captures the time base.
- R5: Writing the interval register loads both the reload value and the count. While running, each cycle with the tick enable high decrements the count. A tick that finds the count at 1 is an expiry and sets status bit 27.
- R6: On expiry the count becomes the reload value when auto-reload (control bit 22) is set. Otherwise it becomes 0 and stays there.
- R7: The interval count holds its value while the reload value is 1 or less or control bit 26 is clear.
- R8: The watchdog tap is time-base bit 17, 21, 25 or 29 for select 0 to 3. On a transition with status bit 31 clear, bit 31 is set. On a transition with bit 31 set and bit 30 clear, bit 30 is set.
- R9: On a transition with status bits 31 and 30 both set, control bits 29:28 are copied into status bits 29:28. If that value is non-zero, the reset request is high for exactly one cycle with the kind on the kind output. A value of zero gives no request.
- R10: The interval interrupt equals status 27 AND control 26. The fixed-interval interrupt equals status 26 AND control 23. The watchdog interrupt equals status 30 AND control 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Interval-timer decrement enable |
| tb_in | input | 64 | Time base value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data |
| sts_we | input | 1 | Status clear strobe |
| sts_wdata | input | 32 | Status bits to clear (ones clear) |
| pit_we | input | 1 | Interval register write strobe |
| pit_wdata | input | 32 | Interval reload and start value |
| ctl_q | output | 32 | Control register value |
| sts_q | output | 32 | Status register value |
| pit_q | output | 32 | Current interval count |
| irq_pit | output | 1 | Interval-timer interrupt |
| irq_fit | output | 1 | Fixed-interval interrupt |
| irq_wdog | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset kind: 1 core, 2 chip, 3 system |

## Verification
A software clear of a status bit can land on the same clock edge as the timer event that sets that bit. The bench forces this in two places. It issues the clear on the edge where the interval count expires, and again on the edge where the selected fixed-interval bit flips. In both cases it expects the bit to read as set afterwards. Randomly chosen tap selects, with noise on the lower time-base bits, show that only the selected bit raises an event. Directed runs walk the watchdog through both stages, the reset kind and the field lock.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 2;

  // control field positions
  localparam int C_WD_PER  = 30;
  localparam int C_WD_RST  = 28;
  localparam int C_WD_IE   = 27;
  localparam int C_PIT_IE  = 26;
  localparam int C_FIT_PER = 24;
  localparam int C_FIT_IE  = 23;
  localparam int C_PIT_AR  = 22;

  // status field positions
  localparam int S_WD_ENP = 31;
  localparam int S_WD_IS  = 30;
  localparam int S_WD_REC = 28;
  localparam int S_PIT    = 27;
  localparam int S_FIT    = 26;

  localparam logic [REG_W-1:0] CTL_MASK = 32'hFFC0_0000;
  localparam logic [REG_W-1:0] STS_MASK = 32'hFC00_0000;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CORE = 2'd1,
    RK_CHIP = 2'd2,
    RK_SYS  = 2'd3
  } rst_kind_e;
endpackage

// File: rtl/ctu_tap_edge.sv
module ctu_tap_edge #(
  parameter int SEL_W = 2,
  localparam int N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     taps,
  input  logic [SEL_W-1:0] sel,
  output logic             ev
);
  logic [N-1:0] prev_q;
  logic         armed_q;

  // all candidates are tracked so a select change raises no event
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= taps;
      armed_q <= 1'b1;
    end
  end

  assign ev = armed_q & (taps[sel] ^ prev_q[sel]);
endmodule

// File: rtl/ctu_pit.sv
module ctu_pit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run_en,
  input  logic         auto_rl,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] reload_q;
  logic         running;
  logic         step;

  assign running = run_en && (reload_q > W'(1));
  assign step    = !ld && running && tick && (count != '0);
  assign expire  = step && (count == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count    <= '0;
    end else if (ld) begin
      reload_q <= ld_val;
      count    <= ld_val;
    end else if (expire) begin
      count <= auto_rl ? reload_q : '0;
    end else if (step) begin
      count <= count - W'(1);
    end
  end
endmodule

// File: rtl/ctu_wdog.sv
module ctu_wdog
  import ctu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev,
  input  logic       enp,
  input  logic       wis,
  input  logic [1:0] rctl,
  output logic       set_enp,
  output logic       set_wis,
  output logic       fire,
  output logic       rst_req,
  output logic [1:0] rst_kind
);
  rst_kind_e kind_q;

  assign set_enp = ev & ~enp;
  assign set_wis = ev & enp & ~wis;
  assign fire    = ev & enp & wis;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      kind_q  <= RK_NONE;
    end else begin
      rst_req <= fire && (rst_kind_e'(rctl) != RK_NONE);
      kind_q  <= fire ? rst_kind_e'(rctl) : RK_NONE;
    end
  end

  assign rst_kind = kind_q;
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
  import ctu_pkg::*;
#(
  parameter int TB_W     = 64,
  parameter int FIT_BASE = 9,
  parameter int WD_BASE  = 17,
  parameter int TAP_STEP = 4,
  localparam int NTAP    = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [TB_W-1:0]  tb_in,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sts_we,
  input  logic [REG_W-1:0] sts_wdata,
  input  logic             pit_we,
  input  logic [REG_W-1:0] pit_wdata,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] pit_q,
  output logic             irq_pit,
  output logic             irq_fit,
  output logic             irq_wdog,
  output logic             rst_req,
  output logic [1:0]       rst_kind
);
  logic [REG_W-1:0] ctl_r, ctl_n, sts_r, sts_n, pit_cnt;
  logic [NTAP-1:0]  fit_taps, wd_taps;
  logic fit_ev, wd_ev, pit_exp, set_enp, set_wis, wd_fire;
  logic tb_unused;

  assign tb_unused = ^tb_in;

  for (genvar g = 0; g < NTAP; g++) begin : g_taps
    assign fit_taps[g] = tb_in[FIT_BASE + TAP_STEP*g];
    assign wd_taps[g]  = tb_in[WD_BASE + TAP_STEP*g];
  end

  ctu_tap_edge #(.SEL_W(SEL_W)) u_fit_tap (
    .clk  (clk),
    .rst  (rst),
    .taps (fit_taps),
    .sel  (ctl_r[C_FIT_PER +: SEL_W]),
    .ev   (fit_ev)
  );

  ctu_tap_edge #(.SEL_W(SEL_W)) u_wd_tap (
    .clk  (clk),
    .rst  (rst),
    .taps (wd_taps),
    .sel  (ctl_r[C_WD_PER +: SEL_W]),
    .ev   (wd_ev)
  );

  ctu_pit #(.W(REG_W)) u_pit (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_en),
    .run_en  (ctl_r[C_PIT_IE]),
    .auto_rl (ctl_r[C_PIT_AR]),
    .ld      (pit_we),
    .ld_val  (pit_wdata),
    .count   (pit_cnt),
    .expire  (pit_exp)
  );

  ctu_wdog u_wdog (
    .clk      (clk),
    .rst      (rst),
    .ev       (wd_ev),
    .enp      (sts_r[S_WD_ENP]),
    .wis      (sts_r[S_WD_IS]),
    .rctl     (ctl_r[C_WD_RST +: 2]),
    .set_enp  (set_enp),
    .set_wis  (set_wis),
    .fire     (wd_fire),
    .rst_req  (rst_req),
    .rst_kind (rst_kind)
  );

  // control: reset-kind field sticks once non-zero
  always_comb begin
    ctl_n = ctl_r;
    if (ctl_we) begin
      ctl_n = ctl_wdata & CTL_MASK;
      if (ctl_r[C_WD_RST +: 2] != 2'b00)
        ctl_n[C_WD_RST +: 2] = ctl_r[C_WD_RST +: 2];
    end
  end

  // status: clear first, then events set (set wins)
  always_comb begin
    sts_n = sts_r;
    if (sts_we) sts_n = sts_r & ~sts_wdata;
    if (fit_ev)  sts_n[S_FIT]    = 1'b1;
    if (pit_exp) sts_n[S_PIT]    = 1'b1;
    if (set_enp) sts_n[S_WD_ENP] = 1'b1;
    if (set_wis) sts_n[S_WD_IS]  = 1'b1;
    if (wd_fire) sts_n[S_WD_REC +: 2] = ctl_r[C_WD_RST +: 2];
    sts_n = sts_n & STS_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r    <= '0;
      sts_r    <= '0;
      irq_pit  <= 1'b0;
      irq_fit  <= 1'b0;
      irq_wdog <= 1'b0;
    end else begin
      ctl_r    <= ctl_n;
      sts_r    <= sts_n;
      irq_pit  <= sts_n[S_PIT]   & ctl_n[C_PIT_IE];
      irq_fit  <= sts_n[S_FIT]   & ctl_n[C_FIT_IE];
      irq_wdog <= sts_n[S_WD_IS] & ctl_n[C_WD_IE];
    end
  end

  assign ctl_q = ctl_r;
  assign sts_q = sts_r;
  assign pit_q = pit_cnt;
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker (
  input logic        clk,
  input logic        rst,
  input logic        tick_en,
  input logic        pit_we,
  input logic [31:0] ctl_q,
  input logic [31:0] sts_q,
  input logic [31:0] pit_q,
  input logic        irq_pit,
  input logic        irq_fit,
  input logic        irq_wdog,
  input logic        rst_req,
  input logic [1:0]  rst_kind
);
  // R10
  irq_map_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pit == (sts_q[27] & ctl_q[26])) &&
    (irq_fit == (sts_q[26] & ctl_q[23])) &&
    (irq_wdog == (sts_q[30] & ctl_q[27])));

  // R9
  rst_kind_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (rst_kind != 2'd0) && (sts_q[29:28] == rst_kind));

  // R2
  rst_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(ctl_q[29:28]) != 2'd0)) |-> $stable(ctl_q[29:28]));

  // R8
  wd_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q[30]) |-> $past(sts_q[31]));

  // R5
  pit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !pit_we) |=> $stable(pit_q));
endmodule

bind core_timer_unit ctu_checker u_chk (.*);

// File: tb/core_timer_unit_tb.sv
module core_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [63:0] tb_in = '0;
  logic        ctl_we = 1'b0, sts_we = 1'b0, pit_we = 1'b0;
  logic [31:0] ctl_wdata = '0, sts_wdata = '0, pit_wdata = '0;
  logic [31:0] ctl_q, sts_q, pit_q;
  logic        irq_pit, irq_fit, irq_wdog, rst_req;
  logic [1:0]  rst_kind;

  int checks = 0;
  int errors = 0;
  logic [63:0] tbv = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  core_timer_unit u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .tb_in(tb_in),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .pit_we(pit_we), .pit_wdata(pit_wdata),
    .ctl_q(ctl_q), .sts_q(sts_q), .pit_q(pit_q),
    .irq_pit(irq_pit), .irq_fit(irq_fit), .irq_wdog(irq_wdog),
    .rst_req(rst_req), .rst_kind(rst_kind)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_we = 1'b1; ctl_wdata = v; step(); ctl_we = 1'b0;
  endtask

  task automatic clr_sts(input logic [31:0] v);
    sts_we = 1'b1; sts_wdata = v; step(); sts_we = 1'b0;
  endtask

  task automatic wr_pit(input logic [31:0] v);
    pit_we = 1'b1; pit_wdata = v; step(); pit_we = 1'b0;
  endtask

  task automatic flip(input int k);
    tbv = tbv ^ (64'd1 << k); tb_in = tbv; step();
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1; repeat (n) step(); tick_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (2) step(); rst = 1'b0; step();
  endtask

  function automatic logic [31:0] fit_ctl(input int sel, input bit en);
    return (32'(sel) << 24) | (32'(en) << 23);
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        checks++; errors++;
        $display("FAIL R1 watchdog actual=%0d expected<50000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 ctl", ctl_q, 0);
    chk("R1 sts", sts_q, 0);
    chk("R1 pit", pit_q, 0);
    chk("R1 outs", {irq_pit, irq_fit, irq_wdog, rst_req, rst_kind}, 0);

    // R2 field storage and masking
    wr_ctl(32'hC5FF_FFFF & 32'hCFFF_FFFF);
    chk("R2 ctl mask", ctl_q, 32'hC5C0_0000);

    // R4 fixed interval, select 1 -> bit 13
    flip(9);
    chk("R4 other tap ignored", sts_q, 0);
    flip(13);
    chk("R4 rising event", sts_q, 32'h0400_0000);
    chk("R10 fit irq", irq_fit, 1);
    clr_sts(32'h0400_0000);
    chk("R3 w1c", sts_q, 0);
    chk("R10 fit irq low", irq_fit, 0);
    flip(13);
    chk("R4 falling event", sts_q[26], 1);
    clr_sts(32'hFFFF_FFFF);
    sts_we = 1'b1; sts_wdata = 32'h0400_0000; tbv ^= 64'd1 << 13; tb_in = tbv;
    step(); sts_we = 1'b0;
    chk("R3 fit set beats clear", sts_q[26], 1);

    // R5 interval timer, no auto reload
    wr_ctl(32'h0400_0000);
    clr_sts(32'hFFFF_FFFF);
    wr_pit(5);
    chk("R5 load", pit_q, 5);
    ticks(4);
    chk("R5 count", pit_q, 1);
    chk("R5 not yet", sts_q[27], 0);
    ticks(1);
    chk("R5 expiry", sts_q[27], 1);
    chk("R10 pit irq", irq_pit, 1);
    chk("R6 no reload zero", pit_q, 0);
    ticks(3);
    chk("R6 stays zero", pit_q, 0);

    // R6 auto reload
    wr_ctl(32'h0440_0000);
    clr_sts(32'h0800_0000);
    wr_pit(3);
    ticks(2);
    chk("R5 count2", pit_q, 1);
    ticks(1);
    chk("R6 reloaded", pit_q, 3);
    chk("R6 status", sts_q[27], 1);
    ticks(1);
    chk("R6 runs on", pit_q, 2);

    // R7 stopped by enable
    wr_ctl(32'h0040_0000);
    chk("R10 pit irq masked", irq_pit, 0);
    ticks(4);
    chk("R7 disabled holds", pit_q, 2);

    // R7 reload of one
    wr_ctl(32'h0440_0000);
    clr_sts(32'hFFFF_FFFF);
    wr_pit(1);
    ticks(5);
    chk("R7 reload one holds", pit_q, 1);
    chk("R7 no expiry", sts_q[27], 0);

    // R3 expiry in same cycle as clear
    wr_pit(2);
    ticks(1);
    tick_en = 1'b1; sts_we = 1'b1; sts_wdata = 32'h0800_0000;
    step();
    tick_en = 1'b0; sts_we = 1'b0;
    chk("R3 pit set beats clear", sts_q[27], 1);
    chk("R6 collision reload", pit_q, 2);

    // R4 random tap selection
    for (int i = 0; i < 24; i++) begin
      int sel, k;
      bit en;
      sel = int'($urandom % 4);
      k   = int'($urandom % 4);
      en  = bit'($urandom % 2);
      wr_ctl(fit_ctl(sel, en));
      clr_sts(32'hFFFF_FFFF);
      tbv = tbv ^ (64'($urandom) & 64'h1FF) ^ (64'd1 << (9 + 4*k));
      tb_in = tbv;
      step();
      chk("R4 random tap", sts_q[26], (k == sel));
      chk("R10 random irq", irq_fit, (k == sel) && en);
      chk("R9 no request for kind 0", rst_req, 0);
    end

    // R8/R9 watchdog
    do_reset();
    wr_ctl(32'h0800_0000);
    flip(17);
    chk("R8 stage one", sts_q, 32'h8000_0000);
    chk("R10 wd irq low", irq_wdog, 0);
    flip(17);
    chk("R8 stage two", sts_q, 32'hC000_0000);
    chk("R10 wd irq", irq_wdog, 1);
    flip(17);
    chk("R9 kind zero no req", rst_req, 0);
    chk("R9 kind zero record", sts_q, 32'hC000_0000);
    wr_ctl(32'h2800_0000);
    flip(17);
    chk("R9 request", rst_req, 1);
    chk("R9 kind", rst_kind, 2);
    chk("R9 record", sts_q, 32'hE000_0000);
    step();
    chk("R9 one cycle", rst_req, 0);
    wr_ctl(32'h3800_0000);
    chk("R2 kind locked", ctl_q, 32'h2800_0000);
    clr_sts(32'hF000_0000);
    chk("R3 wd clear", sts_q, 0);
    flip(17);
    chk("R8 restart", sts_q, 32'h8000_0000);
    chk("R9 no req stage one", rst_req, 0);
    wr_ctl(32'h6800_0000);
    chk("R2 select change", ctl_q, 32'h6800_0000);
    flip(17);
    chk("R8 old tap ignored", sts_q, 32'h8000_0000);
    flip(21);
    chk("R8 new tap", sts_q, 32'hC000_0000);

    // R2 lock released by reset
    do_reset();
    chk("R1 second reset", {ctl_q, sts_q}, 0);
    wr_ctl(32'h1000_0000);
    chk("R2 unlocked after reset", ctl_q, 32'h1000_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule